// File: doc/BRIEF.md
# Programmable Interval Counter Channel

This block is one channel of a programmable interval timer. It holds a down-counter, a write-side holding register for the next count, and the control logic that shapes a single output pin into one of five waveforms. These are: a level that rises at terminal count, a retriggerable one-shot pulse, a periodic divide-by-N strobe, a strobe started by software, and a strobe started by a gate edge. A separate host interface decodes the bus and the control word. It presents this channel with a mode write strobe, a count write strobe and a hold request that is raised while a multi-byte count is only partly written.

Everything runs on the counting clock. The gate input crosses a parameterised synchroniser before it is used. The counter therefore sees a gate change `SYNC_STAGES + 1` edges after it appears at the pin. A count written by the host sits in the holding register, with the null-count flag set, until the mode's transfer rule moves it into the counter.

Top module: `pit_channel`

## Requirements
- R1: The counter is `CNT_W` bits wide and `count_o` shows its live value. After a transfer it equals the written count and then drops by one on every counting edge.
- R2: In mode 0 (`mode_sel` = 3'd0), a mode write drives `out_o` low. A written count is transferred on the following edge with `out_o` low. `out_o` rises on the edge at which the count reaches zero, which is N edges after the transfer. It then stays high until the next count write or mode write.
- R3: In mode 0, each cycle with `hold_i` high suspends one decrement. In every other mode, `hold_i` has no effect.
- R4: In mode 1 (3'd1), writing a count only arms the channel: `out_o` stays high and `null_o` stays set. A synchronised rising gate edge loads the count and drives `out_o` low for N cycles.
- R5: In mode 1, a rising gate edge during a pulse reloads the most recently written count. A count written during a pulse without a gate edge leaves the length of that pulse unchanged.
- R6: In mode 2 (3'd2), `out_o` goes low for exactly one cycle when the count reaches 1, the count reloads, and the period is N cycles. A count written while running takes effect at the next reload. A rising gate edge reloads at once.
- R7: In strobe modes 4 (3'd4, transfer on the edge after the write) and 5 (3'd5, loaded by a rising gate edge), `out_o` is high while counting. It gives one single-cycle low pulse N edges after the load and no further pulse until the next load.
- R8: Modes 0, 2 and 4 decrement only while the synchronised gate is high, and mode 2 holds `out_o` high while the gate is low. Modes 1 and 5 ignore the gate level and act only on its rising edge. The counter sees any gate change `SYNC_STAGES + 1` edges after the pin.
- R9: `null_o` is set on the edge that captures a count write and clears on the edge that transfers that count into the counter.
- R10: A written count of zero counts 2^`CNT_W` edges.
- R11: A mode write with `mode_sel` of 3'd3, 3'd6 or 3'd7 is ignored, and the running mode carries on unchanged.
- R12: After reset the channel is in mode 0 with `out_o` high, `null_o` low and `count_o` zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counting clock |
| rst | input | 1 | Synchronous active-high reset |
| gate_i | input | 1 | Gate pin, asynchronous |
| mode_wr_i | input | 1 | Mode write strobe from the host interface |
| mode_sel_i | input | 3 | Mode number captured with `mode_wr_i` |
| load_stb_i | input | 1 | Count write strobe |
| load_val_i | input | CNT_W | Count value captured with `load_stb_i` |
| hold_i | input | 1 | Suspends counting in mode 0 while a count is half written |
| out_o | output | 1 | Timer output pin |
| null_o | output | 1 | A written count has not yet reached the counter |
| count_o | output | CNT_W | Live counter value |

## Verification
The bench builds the channel with `CNT_W` = 4 and `SYNC_STAGES` = 2. With that width, every count from 1 to 15 can be swept in every mode, and the zero count, which stands for 16, is reached within a few cycles. With a two-stage synchroniser, the three-edge gate latency is a small constant, so the bench can predict trigger and retrigger delays and the stretching caused by gate-low or hold windows by plain arithmetic on N.

// File: rtl/pit_pkg.sv
package pit_pkg;

    typedef enum logic [2:0] {
        M_TC   = 3'd0,
        M_OS   = 3'd1,
        M_RATE = 3'd2,
        M_SWS  = 3'd4,
        M_HWS  = 3'd5
    } mode_e;

    typedef struct packed {
        logic ld;
        logic dec;
    } cnt_cmd_t;

    function automatic logic mode_valid(input logic [2:0] sel);
        return (sel == 3'd0) || (sel == 3'd1) || (sel == 3'd2) ||
               (sel == 3'd4) || (sel == 3'd5);
    endfunction

    function automatic logic level_gated(input mode_e m);
        return (m == M_TC) || (m == M_RATE) || (m == M_SWS);
    endfunction

endpackage

// File: rtl/pit_gate_sync.sv
module pit_gate_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic gate_i,
    output logic lvl_o,
    output logic rise_o
);
    localparam int TOP = (STAGES < 2) ? 1 : STAGES - 1;

    logic [TOP:0] chain_q;
    logic         last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain_q <= '0;
            last_q  <= 1'b0;
        end else begin
            chain_q <= {chain_q[TOP-1:0], gate_i};
            last_q  <= chain_q[TOP];
        end
    end

    assign lvl_o  = chain_q[TOP];
    assign rise_o = chain_q[TOP] & ~last_q;

endmodule

// File: rtl/pit_down_counter.sv
module pit_down_counter
    import pit_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  cnt_cmd_t         cmd_i,
    input  logic [CNT_W-1:0] ld_val_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             is1_o,
    output logic             is2_o
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
    localparam logic [CNT_W-1:0] TWO = CNT_W'(2);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (cmd_i.ld) begin
            cnt_q <= ld_val_i;
        end else if (cmd_i.dec) begin
            cnt_q <= cnt_q - ONE;
        end
    end

    assign cnt_o = cnt_q;
    assign is1_o = (cnt_q == ONE);
    assign is2_o = (cnt_q == TWO);

endmodule

// File: rtl/pit_chan_ctrl.sv
module pit_chan_ctrl
    import pit_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             mode_wr_i,
    input  logic [2:0]       mode_sel_i,
    input  logic             load_stb_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             hold_i,
    input  logic             gate_lvl_i,
    input  logic             gate_rise_i,
    input  logic             is1_i,
    input  logic             is2_i,
    output cnt_cmd_t         cmd_o,
    output logic [CNT_W-1:0] reload_o,
    output mode_e            mode_o,
    output logic             out_o,
    output logic             null_o
);
    mode_e            mode_q;
    logic             out_q, out_nxt;
    logic             fired_q, fired_nxt;
    logic             null_q, armed_q, xfer_q, run_q;
    logic [CNT_W-1:0] reload_q;
    logic             wr_ok;
    cnt_cmd_t         cmd;

    assign wr_ok = mode_wr_i && mode_valid(mode_sel_i);

    always_comb begin
        cmd       = '0;
        out_nxt   = out_q;
        fired_nxt = fired_q;
        if (!wr_ok) begin
            case (mode_q)
                M_TC: begin
                    if (xfer_q) begin
                        cmd.ld  = 1'b1;
                        out_nxt = 1'b0;
                    end else if (run_q && gate_lvl_i && !hold_i) begin
                        cmd.dec = 1'b1;
                        if (is1_i) out_nxt = 1'b1;
                    end
                end
                M_OS: begin
                    if (gate_rise_i && armed_q) begin
                        cmd.ld  = 1'b1;
                        out_nxt = 1'b0;
                    end else if (run_q) begin
                        cmd.dec = 1'b1;
                        if (is1_i) out_nxt = 1'b1;
                    end
                end
                M_RATE: begin
                    if (!run_q) begin
                        if (xfer_q) begin
                            cmd.ld  = 1'b1;
                            out_nxt = 1'b1;
                        end
                    end else if (!gate_lvl_i) begin
                        out_nxt = 1'b1;
                    end else if (gate_rise_i || is1_i) begin
                        cmd.ld  = 1'b1;
                        out_nxt = 1'b1;
                    end else begin
                        cmd.dec = 1'b1;
                        if (is2_i) out_nxt = 1'b0;
                    end
                end
                M_SWS: begin
                    if (xfer_q) begin
                        cmd.ld    = 1'b1;
                        out_nxt   = 1'b1;
                        fired_nxt = 1'b0;
                    end else begin
                        if (!out_q) out_nxt = 1'b1;
                        if (run_q && gate_lvl_i) begin
                            cmd.dec = 1'b1;
                            if (is1_i && !fired_q) begin
                                out_nxt   = 1'b0;
                                fired_nxt = 1'b1;
                            end
                        end
                    end
                end
                M_HWS: begin
                    if (gate_rise_i && armed_q) begin
                        cmd.ld    = 1'b1;
                        out_nxt   = 1'b1;
                        fired_nxt = 1'b0;
                    end else begin
                        if (!out_q) out_nxt = 1'b1;
                        if (run_q) begin
                            cmd.dec = 1'b1;
                            if (is1_i && !fired_q) begin
                                out_nxt   = 1'b0;
                                fired_nxt = 1'b1;
                            end
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q   <= M_TC;
            out_q    <= 1'b1;
            fired_q  <= 1'b0;
            null_q   <= 1'b0;
            armed_q  <= 1'b0;
            xfer_q   <= 1'b0;
            run_q    <= 1'b0;
            reload_q <= '0;
        end else if (wr_ok) begin
            mode_q  <= mode_e'(mode_sel_i);
            out_q   <= (mode_sel_i != 3'd0);
            fired_q <= 1'b0;
            null_q  <= 1'b0;
            armed_q <= 1'b0;
            xfer_q  <= 1'b0;
            run_q   <= 1'b0;
        end else begin
            out_q   <= out_nxt;
            fired_q <= fired_nxt;
            if (cmd.ld) begin
                null_q <= 1'b0;
                xfer_q <= 1'b0;
                run_q  <= 1'b1;
            end
            if (load_stb_i) begin
                reload_q <= load_val_i;
                null_q   <= 1'b1;
                armed_q  <= 1'b1;
                xfer_q   <= 1'b1;
            end
        end
    end

    assign cmd_o    = cmd;
    assign reload_o = reload_q;
    assign mode_o   = mode_q;
    assign out_o    = out_q;
    assign null_o   = null_q;

    AST_NULL_SET_ON_LOAD: assert property (@(posedge clk) disable iff (rst)
        load_stb_i && !mode_wr_i |=> null_q);  // R9

    AST_STROBE_ONE_CLK: assert property (@(posedge clk) disable iff (rst)
        (mode_q == M_SWS || mode_q == M_HWS || mode_q == M_RATE) && !out_q && !mode_wr_i
        |=> out_q);  // R7

    AST_OS_FALL_ON_TRIGGER: assert property (@(posedge clk) disable iff (rst)
        (mode_q == M_OS) && $fell(out_q) |-> $past(gate_rise_i));  // R4

endmodule

// File: rtl/pit_channel.sv
module pit_channel
    import pit_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             gate_i,
    input  logic             mode_wr_i,
    input  logic [2:0]       mode_sel_i,
    input  logic             load_stb_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             hold_i,
    output logic             out_o,
    output logic             null_o,
    output logic [CNT_W-1:0] count_o
);
    logic             gate_lvl, gate_rise;
    logic             is1, is2;
    cnt_cmd_t         cmd;
    logic [CNT_W-1:0] reload;
    mode_e            mode;

    pit_gate_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .gate_i (gate_i),
        .lvl_o  (gate_lvl),
        .rise_o (gate_rise)
    );

    pit_chan_ctrl #(.CNT_W(CNT_W)) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .mode_wr_i   (mode_wr_i),
        .mode_sel_i  (mode_sel_i),
        .load_stb_i  (load_stb_i),
        .load_val_i  (load_val_i),
        .hold_i      (hold_i),
        .gate_lvl_i  (gate_lvl),
        .gate_rise_i (gate_rise),
        .is1_i       (is1),
        .is2_i       (is2),
        .cmd_o       (cmd),
        .reload_o    (reload),
        .mode_o      (mode),
        .out_o       (out_o),
        .null_o      (null_o)
    );

    pit_down_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .cmd_i    (cmd),
        .ld_val_i (reload),
        .cnt_o    (count_o),
        .is1_o    (is1),
        .is2_o    (is2)
    );

    AST_TC_RISE_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
        (mode == M_TC) && $rose(out_o) |-> (count_o == '0));  // R2

    AST_RATE_LOW_AT_ONE: assert property (@(posedge clk) disable iff (rst)
        (mode == M_RATE) && $fell(out_o) |-> (count_o == CNT_W'(1)));  // R6

    AST_GATE_LOW_FREEZES: assert property (@(posedge clk) disable iff (rst)
        level_gated(mode) && !gate_lvl && !cmd.ld && !mode_wr_i
        |=> count_o == $past(count_o));  // R8

endmodule

// File: tb/test_pit_channel.sv
module test_pit_channel;
    localparam int W   = 4;
    localparam int LAT = 3;   // SYNC_STAGES + 1

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         gate = 1'b1;
    logic         mode_wr = 1'b0;
    logic [2:0]   mode_sel = 3'd0;
    logic         load_stb = 1'b0;
    logic [W-1:0] load_val = '0;
    logic         hold = 1'b0;
    logic         out_w, null_w;
    logic [W-1:0] count_w;

    int n_chk  = 0;
    int n_fail = 0;

    pit_channel #(.CNT_W(W), .SYNC_STAGES(2)) i_pit_channel (
        .clk        (clk),
        .rst        (rst),
        .gate_i     (gate),
        .mode_wr_i  (mode_wr),
        .mode_sel_i (mode_sel),
        .load_stb_i (load_stb),
        .load_val_i (load_val),
        .hold_i     (hold),
        .out_o      (out_w),
        .null_o     (null_w),
        .count_o    (count_w)
    );

    always #4 clk = ~clk;

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=0", 1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic wait_out(input logic val, input int limit, output int n);
        n = 0;
        while (out_w !== val && n < limit) begin
            tick();
            n++;
        end
    endtask

    task automatic mode_write(input logic [2:0] m);
        mode_sel = m;
        mode_wr  = 1'b1;
        tick();
        mode_wr  = 1'b0;
    endtask

    task automatic load(input logic [W-1:0] v);
        load_val = v;
        load_stb = 1'b1;
        tick();
        load_stb = 1'b0;
    endtask

    function automatic int span(input int v);
        return (v == 0) ? (1 << W) : v;
    endfunction

    initial begin
        int n, n2, lows;
        ticks(3);
        rst = 1'b0;
        tick();
        check("R12 out after reset", int'(out_w), 1);
        check("R12 null after reset", int'(null_w), 0);
        check("R12 count after reset", int'(count_w), 0);

        // Mode 0 sweep
        mode_write(3'd0);
        check("R2 mode write drives out low", int'(out_w), 0);
        for (int v = 0; v < 16; v++) begin
            load(W'(v));
            check("R9 null set after write", int'(null_w), 1);
            tick();
            check("R9 null cleared on transfer", int'(null_w), 0);
            check("R1 count equals written value", int'(count_w), v);
            check("R2 out low after transfer", int'(out_w), 0);
            tick();
            check("R1 count decrements", int'(count_w), (v + 15) % 16);
            wait_out(1'b1, 40, n);
            check("R2 R10 terminal count delay", n + 1, span(v));
        end
        lows = 0;
        for (int i = 0; i < 40; i++) begin
            tick();
            if (out_w == 1'b0) lows++;
        end
        check("R2 out stays high after terminal", lows, 0);

        // Hold in mode 0
        load(W'(10));
        tick();
        ticks(2);
        hold = 1'b1;
        ticks(3);
        hold = 1'b0;
        wait_out(1'b1, 60, n);
        check("R3 hold stretches count", n, 8);

        // Gate level in mode 0
        load(W'(10));
        tick();
        ticks(2);
        gate = 1'b0;
        ticks(4);
        gate = 1'b1;
        wait_out(1'b1, 60, n);
        check("R8 gate low pauses mode 0", n, 8);

        // One-shot sweep
        gate = 1'b0;
        mode_write(3'd1);
        ticks(4);
        check("R4 out high after mode write", int'(out_w), 1);
        for (int v = 0; v < 16; v++) begin
            if (v == 0) continue;
            load(W'(v));
            ticks(4);
            check("R4 armed only keeps out high", int'(out_w), 1);
            check("R4 armed only keeps null set", int'(null_w), 1);
            gate = 1'b1;
            wait_out(1'b0, 10, n);
            check("R8 trigger latency", n, LAT);
            wait_out(1'b1, 40, n);
            check("R4 pulse length", n, v);
            gate = 1'b0;
            ticks(4);
        end
        load(W'(0));
        ticks(2);
        gate = 1'b1;
        wait_out(1'b0, 10, n);
        wait_out(1'b1, 40, n);
        check("R10 one-shot zero count", n, 16);
        gate = 1'b0;
        ticks(4);

        // Retrigger
        load(W'(8));
        gate = 1'b1;
        wait_out(1'b0, 10, n);
        ticks(2);
        gate = 1'b0;
        ticks(2);
        gate = 1'b1;
        wait_out(1'b1, 40, n);
        check("R5 retrigger restarts pulse", n, LAT + 8);
        gate = 1'b0;
        ticks(4);

        // New count during pulse
        load(W'(8));
        gate = 1'b1;
        wait_out(1'b0, 10, n);
        load(W'(4));
        wait_out(1'b1, 40, n);
        check("R5 write during pulse leaves length", n + 1, 8);
        gate = 1'b0;
        ticks(4);
        gate = 1'b1;
        wait_out(1'b0, 10, n);
        wait_out(1'b1, 40, n);
        check("R5 next trigger uses new count", n, 4);

        // Rate generator sweep
        mode_write(3'd2);
        check("R6 out high after mode write", int'(out_w), 1);
        for (int v = 2; v < 17; v++) begin
            load(W'(v % 16));
            wait_out(1'b0, 40, n);
            wait_out(1'b1, 5, n);
            check("R6 low for one cycle", n, 1);
            wait_out(1'b0, 40, n);
            check("R6 R10 period", n + 1, span(v % 16));
        end

        load(W'(5));
        wait_out(1'b1, 40, n);
        wait_out(1'b0, 40, n);
        wait_out(1'b1, 40, n);
        wait_out(1'b0, 40, n);
        check("R6 new count at next reload", n + 1, 5);

        // Hold ignored in rate mode
        hold = 1'b1;
        wait_out(1'b1, 40, n);
        wait_out(1'b0, 40, n2);
        check("R3 hold has no effect in mode 2", n + n2, 5);
        hold = 1'b0;

        // Null while running in rate mode
        wait_out(1'b1, 40, n);
        load(W'(7));
        check("R9 null set while running", int'(null_w), 1);
        wait_out(1'b0, 40, n);
        wait_out(1'b1, 40, n);
        check("R9 null cleared at reload", int'(null_w), 0);
        wait_out(1'b0, 40, n);
        check("R6 period after reload", n + 1, 7);

        // Gate in rate mode
        load(W'(5));
        wait_out(1'b1, 40, n);
        wait_out(1'b0, 40, n);
        wait_out(1'b1, 40, n);
        gate = 1'b0;
        ticks(4);
        lows = 0;
        for (int i = 0; i < 20; i++) begin
            tick();
            if (out_w == 1'b0) lows++;
        end
        check("R8 gate low holds out high in mode 2", lows, 0);
        gate = 1'b1;
        wait_out(1'b0, 40, n);
        check("R6 R8 gate rise reloads", n, 5 + LAT - 1);

        // Unsupported mode write ignored
        mode_write(3'd3);
        wait_out(1'b1, 40, n);
        wait_out(1'b0, 40, n);
        check("R11 mode 3 ignored", n + 1, 5);
        mode_write(3'd7);
        wait_out(1'b1, 40, n);
        wait_out(1'b0, 40, n);
        check("R11 mode 7 ignored", n + 1, 5);

        // Software strobe sweep
        mode_write(3'd4);
        for (int v = 0; v < 16; v++) begin
            load(W'(v));
            tick();
            check("R7 out high after transfer", int'(out_w), 1);
            check("R1 strobe count loaded", int'(count_w), v);
            wait_out(1'b0, 40, n);
            check("R7 R10 strobe delay", n, span(v));
            wait_out(1'b1, 5, n);
            check("R7 strobe width", n, 1);
            lows = 0;
            for (int i = 0; i < 20; i++) begin
                tick();
                if (out_w == 1'b0) lows++;
            end
            check("R7 single strobe", lows, 0);
        end

        // Hardware strobe sweep
        gate = 1'b0;
        mode_write(3'd5);
        ticks(4);
        for (int v = 1; v < 16; v++) begin
            load(W'(v));
            ticks(4);
            check("R7 hw strobe waits for gate", int'(out_w), 1);
            gate = 1'b1;
            wait_out(1'b0, 40, n);
            check("R7 R8 hw strobe delay", n, LAT + v);
            wait_out(1'b1, 5, n);
            check("R7 hw strobe width", n, 1);
            gate = 1'b0;
            ticks(4);
        end
        load(W'(8));
        gate = 1'b1;
        ticks(5);
        gate = 1'b0;
        ticks(2);
        gate = 1'b1;
        wait_out(1'b0, 40, n);
        check("R7 hw strobe retrigger", n, LAT + 8);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule